// File: doc/BRIEF.md
# Shared Hardware Semaphore Bank

This block holds eight token latches that two processors, one on a left port and one on a right port, use to reserve shared resources. A port asks for a token by writing 0 into it and then reads it back. A read of 0 means the port holds the token. A read of 1 means the other side holds it. The block keeps no memory array of its own. It only decides who holds each token.

A request that is refused is not thrown away. It stays pending, and the token passes to the waiting side on the same clock edge that the holder writes 1. When both ports ask for the same free token on the same edge, the left port gets it and the right request waits. Read results come back through a per-port register, so a later write from the other side cannot change a value that was already returned. The token latches have no reset. After power-up, software frees every token by writing 1 from both sides.

Top module: `sem_bank_top`

## Requirements
- R1: After a clock edge with `rst_n` low, both read-data outputs are all ones (8'hFF). Reset does not change any token's holder or pending requests.
- R2: A write takes effect only when the port's select and write strobe are both high on a clock edge. A read takes effect only when select and read strobe are both high. Strobes given with select low change neither state nor read data.
- R3: The write-data bit sets the request: 0 asks for the token, 1 gives it up or withdraws a pending request. A request to a free token grants it, so afterwards the requester reads 0 and the other port reads 1.
- R4: While one port holds a token, a 0 written by the other port does not take it. The holder keeps reading 0 and the other port keeps reading 1.
- R5: If the other port wrote 0 while the token was held, the token passes to that port on the edge where the holder writes 1. From then on the former holder reads 1 and the new holder reads 0.
- R6: A token given up with no pending request reads 1 from both ports. A non-holder that writes 1 withdraws its pending request, and a later release by the holder then frees the token.
- R7: A read returns, one edge later, the token state from before that edge, copied onto all 8 data bits (8'h00 when the port holds the token, 8'hFF otherwise). A write on the same edge is not seen. The read data holds its value until the next read or reset.
- R8: If both ports write 0 to a free token on the same edge, the left port holds it and the right request waits. The right port then gets the token when the left port releases it.
- R9: The 3-bit index picks one of eight independent tokens. A write to one token does not change any other token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset for the read-data registers |
| l_sel | input | 1 | Left port token select |
| l_wr | input | 1 | Left port write strobe |
| l_rd | input | 1 | Left port read strobe |
| l_idx | input | 3 | Left port token index |
| l_wbit | input | 1 | Left port write bit (0 asks, 1 gives up) |
| l_rdata | output | 8 | Left port read data, token value copied onto every bit |
| r_sel | input | 1 | Right port token select |
| r_wr | input | 1 | Right port write strobe |
| r_rd | input | 1 | Right port read strobe |
| r_idx | input | 3 | Right port token index |
| r_wbit | input | 1 | Right port write bit (0 asks, 1 gives up) |
| r_rdata | output | 8 | Right port read data, token value copied onto every bit |

## Verification
A write changes a token on the clock edge where it is sampled. A read strobe on that same edge still sees the old state. Its result appears on the read-data output right after that edge, so read data trails the read strobe by exactly one edge. The bench drives stimulus on the falling edge and advances its reference model at the rising edge. It compares both read-data outputs on the next falling edge, which is the first point where a registered result can be seen. Because read data holds between reads, the comparison runs every cycle and also checks that idle cycles leave it unchanged.

// File: rtl/sem_pkg.sv
// Package: shared types for the semaphore bank.
// Assumes: two ports only; the holder field matters only when both request bits are set.
package sem_pkg;

    // Which side holds a token once both sides have requested it.
    typedef enum logic {
        HOLD_LEFT  = 1'b0,
        HOLD_RIGHT = 1'b1
    } holder_e;

    // Per-token state: one request bit per side plus the arrival-order holder.
    typedef struct packed {
        logic    want_l;
        logic    want_r;
        holder_e holder;
    } token_t;

endpackage

// File: rtl/sem_req_decode.sv
// Module: sem_req_decode
// Turns one port's select/strobe/index into a one-hot per-token write
// enable and a read enable.
// Assumes: the index is always below NUM_SEM, so no range check is made.
module sem_req_decode #(
    parameter int NUM_SEM = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               sel,
    input  logic               wr,
    input  logic               rd,
    input  logic [IDX_W-1:0]   idx,
    output logic [NUM_SEM-1:0] we_vec,
    output logic               rd_en
);

    // Build a one-hot write enable for the token the index points at.
    always_comb begin
        we_vec = '0;
        if (sel && wr) begin
            we_vec[idx] = 1'b1;
        end
    end

    // A read is only taken while the port is selected.
    always_comb begin
        rd_en = sel && rd;
    end

endmodule

// File: rtl/sem_cell.sv
// Module: sem_cell
// One token latch. It keeps a request bit for each side and, when both
// sides have requested, which one came first. The first requester holds
// the token. Same-edge requests on a free token go to the left side.
// Assumes: the state has no reset on purpose, because software frees
// tokens at start-up. rst_n is used only to qualify the assertions.
module sem_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_we,
    input  logic l_wbit,
    input  logic r_we,
    input  logic r_wbit,
    output logic l_grant,
    output logic r_grant
);

    token_t st_q;
    token_t st_d;
    logic   free_now;

    // Work out the next request bits and the holder from this edge's writes.
    always_comb begin
        st_d = st_q;
        if (l_we) st_d.want_l = ~l_wbit;
        if (r_we) st_d.want_r = ~r_wbit;
        if (st_d.want_l && st_d.want_r) begin
            if (st_q.want_l && st_q.want_r) begin
                st_d.holder = st_q.holder;
            end else if (st_q.want_r && !st_q.want_l) begin
                st_d.holder = HOLD_RIGHT;
            end else begin
                st_d.holder = HOLD_LEFT;
            end
        end else begin
            st_d.holder = st_d.want_r ? HOLD_RIGHT : HOLD_LEFT;
        end
    end

    // Token state register; deliberately not reset.
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Decode which side holds the token right now.
    always_comb begin
        l_grant  = st_q.want_l && (!st_q.want_r || st_q.holder == HOLD_LEFT);
        r_grant  = st_q.want_r && (!st_q.want_l || st_q.holder == HOLD_RIGHT);
        free_now = !st_q.want_l && !st_q.want_r;
    end

    // R3: a lone left request on a free token is granted.
    assert_free_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (free_now && l_we && !l_wbit && !r_we) |=> (l_grant && !r_grant));

    // R4: the left holder keeps the token while the right side writes 0.
    assert_no_steal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (l_grant && r_we && !r_wbit && !l_we) |=> l_grant);

    // R5: a pending right request takes over when the left holder releases.
    assert_handover_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (l_grant && st_q.want_r && l_we && l_wbit && !r_we) |=> r_grant);

    // R6: a release with nothing pending frees the token.
    assert_release_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (l_grant && !st_q.want_r && l_we && l_wbit && !r_we) |=> free_now);

    // R8: same-edge requests on a free token go to the left side.
    assert_tie_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (free_now && l_we && !l_wbit && r_we && !r_wbit) |=> (l_grant && !r_grant));

    // R9: a token nobody writes keeps its state.
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_we && !r_we) |=> ($stable(l_grant) && $stable(r_grant)));

endmodule

// File: rtl/sem_read_reg.sv
// Module: sem_read_reg
// Per-port read-data register. On a read it latches the addressed token's
// value for this port, copied onto every data bit (0 = this port holds it).
// Assumes: grant_vec is this port's view of every token before the edge.
module sem_read_reg #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   idx,
    input  logic [NUM_SEM-1:0] grant_vec,
    output logic [DATA_W-1:0]  rdata
);

    // Capture the read value on a read; reset returns all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '1;
        end else if (rd_en) begin
            rdata <= {DATA_W{~grant_vec[idx]}};
        end
    end

    // R7: the read data holds between reads.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en) |=> $stable(rdata));

    // R7: every data bit carries the same token value.
    assert_replicated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata == '0) || (rdata == '1));

    // R1: reset leaves the read data at all ones.
    assert_reset_ones_R1: assert property (@(posedge clk)
        (!rst_n) |=> (rdata == '1));

endmodule

// File: rtl/sem_bank_top.sv
// Module: sem_bank_top
// Bank of NUM_SEM token latches shared by a left and a right port. It
// decodes each port's access, updates the token cells and returns
// registered read data per port.
// Assumes: ports share one clock; token cells are not reset, only the
// read-data registers are.
module sem_bank_top #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel,
    input  logic              l_wr,
    input  logic              l_rd,
    input  logic [IDX_W-1:0]  l_idx,
    input  logic              l_wbit,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel,
    input  logic              r_wr,
    input  logic              r_rd,
    input  logic [IDX_W-1:0]  r_idx,
    input  logic              r_wbit,
    output logic [DATA_W-1:0] r_rdata
);

    logic [NUM_SEM-1:0] l_we_vec;
    logic [NUM_SEM-1:0] r_we_vec;
    logic [NUM_SEM-1:0] l_grant_vec;
    logic [NUM_SEM-1:0] r_grant_vec;
    logic               l_rd_en;
    logic               r_rd_en;

    // Left port access decode.
    sem_req_decode #(.NUM_SEM(NUM_SEM)) u_dec_l (
        .sel(l_sel), .wr(l_wr), .rd(l_rd), .idx(l_idx),
        .we_vec(l_we_vec), .rd_en(l_rd_en)
    );

    // Right port access decode.
    sem_req_decode #(.NUM_SEM(NUM_SEM)) u_dec_r (
        .sel(r_sel), .wr(r_wr), .rd(r_rd), .idx(r_idx),
        .we_vec(r_we_vec), .rd_en(r_rd_en)
    );

    // One cell per token.
    for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
        sem_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_we(l_we_vec[g]), .l_wbit(l_wbit),
            .r_we(r_we_vec[g]), .r_wbit(r_wbit),
            .l_grant(l_grant_vec[g]), .r_grant(r_grant_vec[g])
        );
    end

    // Left port read register.
    sem_read_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .rd_en(l_rd_en), .idx(l_idx),
        .grant_vec(l_grant_vec), .rdata(l_rdata)
    );

    // Right port read register.
    sem_read_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .rd_en(r_rd_en), .idx(r_idx),
        .grant_vec(r_grant_vec), .rdata(r_rdata)
    );

    // R4: no token is ever held by both sides.
    assert_single_holder_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (l_grant_vec & r_grant_vec) == '0);

    // R2: an unselected left port never produces a write enable.
    assert_unselected_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_sel) |-> (l_we_vec == '0 && !l_rd_en));

endmodule

// File: tb/sem_bank_top_bench.sv
module sem_bank_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_sel = 0, l_wr = 0, l_rd = 0, l_wbit = 1;
    logic       r_sel = 0, r_wr = 0, r_rd = 0, r_wbit = 1;
    logic [2:0] l_idx = 0, r_idx = 0;
    logic [7:0] l_rdata, r_rdata;

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Reference model: arrival stamps per side (0 = no request).
    int         stamp_l [8];
    int         stamp_r [8];
    int         seq = 0;
    logic [7:0] exp_l = 8'hFF;
    logic [7:0] exp_r = 8'hFF;

    always #10 clk = ~clk;

    sem_bank_top u_sem_bank_top (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_wr(l_wr), .l_rd(l_rd), .l_idx(l_idx), .l_wbit(l_wbit), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_wr(r_wr), .r_rd(r_rd), .r_idx(r_idx), .r_wbit(r_wbit), .r_rdata(r_rdata)
    );

    function automatic bit holds_l(int i);
        return stamp_l[i] != 0 && (stamp_r[i] == 0 || stamp_l[i] < stamp_r[i]);
    endfunction

    function automatic bit holds_r(int i);
        return stamp_r[i] != 0 && (stamp_l[i] == 0 || stamp_r[i] < stamp_l[i]);
    endfunction

    // Advance the model by one rising edge using the driven inputs.
    task automatic model_edge();
        if (!rst_n) begin
            exp_l = 8'hFF;
            exp_r = 8'hFF;
        end else begin
            if (l_sel && l_rd) exp_l = holds_l(l_idx) ? 8'h00 : 8'hFF;
            if (r_sel && r_rd) exp_r = holds_r(r_idx) ? 8'h00 : 8'hFF;
        end
        if (l_sel && l_wr) begin
            if (!l_wbit) begin
                if (stamp_l[l_idx] == 0) begin seq++; stamp_l[l_idx] = seq; end
            end else stamp_l[l_idx] = 0;
        end
        if (r_sel && r_wr) begin
            if (!r_wbit) begin
                if (stamp_r[r_idx] == 0) begin seq++; stamp_r[r_idx] = seq; end
            end else stamp_r[r_idx] = 0;
        end
    endtask

    task automatic compare();
        checks++;
        if (l_rdata !== exp_l) begin
            errors++;
            $display("FAIL %s left rdata actual=%h expected=%h", cur_req, l_rdata, exp_l);
        end
        checks++;
        if (r_rdata !== exp_r) begin
            errors++;
            $display("FAIL %s right rdata actual=%h expected=%h", cur_req, r_rdata, exp_r);
        end
    endtask

    // One cycle: drive at the falling edge, model at the rising edge, compare at the next falling edge.
    task automatic cyc(input bit ls, lw, lr, input int li, input bit ld,
                       input bit rs, rw, rr, input int ri, input bit rd);
        l_sel = ls; l_wr = lw; l_rd = lr; l_idx = 3'(li); l_wbit = ld;
        r_sel = rs; r_wr = rw; r_rd = rr; r_idx = 3'(ri); r_wbit = rd;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();       cyc(0,0,0,0,1, 0,0,0,0,1); endtask
    task automatic wl(int i, bit d); cyc(1,1,0,i,d, 0,0,0,0,1); endtask
    task automatic wr(int i, bit d); cyc(0,0,0,0,1, 1,1,0,i,d); endtask
    task automatic rdb(int i);     cyc(1,0,1,i,1, 1,0,1,i,1); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin stamp_l[i] = 0; stamp_r[i] = 0; end
        @(negedge clk);
        // R1: reset state of read data.
        cur_req = "R1"; rst_n = 0; idle(); idle(); rst_n = 1;
        // R6: software start-up frees every token from both sides.
        cur_req = "R6";
        for (int i = 0; i < 8; i++) cyc(1,1,0,i,1, 1,1,0,i,1);
        for (int i = 0; i < 8; i++) rdb(i);
        // R3: a lone request on a free token is granted.
        cur_req = "R3"; wl(2,0); rdb(2);
        // R4: the other side's 0 does not take a held token.
        cur_req = "R4"; wr(2,0); rdb(2); idle();
        // R5: the holder's release passes the token to the pending side.
        cur_req = "R5"; wl(2,1); rdb(2);
        // R6: withdrawal of a pending request, then release frees the token.
        cur_req = "R6"; wl(2,0); rdb(2); wl(2,1); wr(2,1); rdb(2);
        // R8: same-edge requests go to the left side, the right one waits.
        cur_req = "R8"; cyc(1,1,0,4,0, 1,1,0,4,0); rdb(4); wl(4,1); rdb(4); wr(4,1); rdb(4);
        // R7: a read on the write edge sees the old state; data holds afterwards.
        cur_req = "R7"; cyc(1,1,1,1,0, 0,0,0,0,1); idle(); idle(); rdb(1); wl(1,1); idle(); rdb(1);
        // R2: strobes with select low are ignored.
        cur_req = "R2"; cyc(0,1,1,3,0, 0,1,1,3,0); rdb(3); cyc(0,0,1,3,1, 0,0,1,3,1);
        // R9: tokens are independent.
        cur_req = "R9"; wl(0,0); wr(7,0);
        for (int i = 0; i < 8; i++) rdb(i);
        // R1: reset keeps token holders.
        cur_req = "R1"; rst_n = 0; idle(); rst_n = 1; rdb(0); rdb(7);
        wl(0,1); wr(7,1);
        // R3: mixed traffic on both ports against the model.
        cur_req = "R3";
        for (int n = 0; n < 4000; n++) begin
            cyc($urandom_range(0,5) != 0, $urandom_range(0,1), $urandom_range(0,1),
                $urandom_range(0,7), $urandom_range(0,1),
                $urandom_range(0,5) != 0, $urandom_range(0,1), $urandom_range(0,1),
                $urandom_range(0,7), $urandom_range(0,1));
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule